// File: doc/BRIEF.md
# Packet-Driven Memory Request Responder

This block is the target side of a narrow memory channel with no separate address or strobe wires. A master sends a request as four consecutive byte-wide beats on a receive lane. Each beat has its own parity lane. The request names one of four operations, a device number, a target address and a transfer length. If the device number matches the block's own, the block answers on a transmit lane with a single acknowledge beat. The beat is positive when the request can be served at once. It is negative when the request arrived with a parity fault or the local memory reports busy, and the master then resends.

After a positive acknowledge, a read streams the requested bytes back one per cycle. A write accepts that many data beats from the master and stores each one. Reads and writes go either to an attached byte-wide memory, whose read port is combinational, or to a small bank of internal control registers.

Top module: `pkt_mem_responder`

## Requirements
- R1: During and directly after reset, `tx_valid`, `mem_rd` and `mem_wr` are low, and every control register holds zero.
- R2: A request is four beats, with `rx_valid` high and captured on successive rising edges.
  - Beat 0 carries the opcode in bits 7:6 and the device number in bits 5:0. The opcodes are 00 memory read, 01 memory write, 10 register read and 11 register write.
  - Beat 1 is the address high byte and beat 2 the address low byte. The address is the low `ADDR_W` bits of {high,low}.
  - Beat 3 is the byte count.
- R3: A request whose device number differs from `LOCAL_ID` produces no transmit beat and no memory or register access.
- R4: A matching request with no parity fault is answered by an acknowledge beat of 0xF0. The beat appears in the cycle after the fourth request beat. For memory opcodes, `mem_ready` must also have been high during the fourth beat.
- R5: A matching, parity-clean memory request with `mem_ready` low during the fourth beat is answered with 0x0F and nothing follows. Register opcodes ignore `mem_ready`.
- R6: A parity fault on any of the four request beats of a matching request gives the 0x0F answer.
- R7: Parity is odd on both lanes: `rx_par`/`tx_par` together with the eight data bits hold an odd number of ones. Every transmit beat obeys this.
- R8: After a positive acknowledge to a memory read, `count` bytes follow on consecutive cycles with no gap. Byte k comes from address (start+k) modulo 2^ADDR_W. `tx_valid` drops after the last byte.
- R9: After a positive acknowledge to a memory write, each later `rx_valid` beat writes the next address. `mem_wr`, `mem_addr` and `mem_wdata` are presented in the same cycle as the beat. The block returns to idle after `count` beats.
- R10: A write data beat with a parity fault is not stored, but it still uses up its address slot and its share of the count.
- R11: Register operations start at index (address mod NREGS) and step by one, wrapping to index 0.
- R12: A byte count of 0 means 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive beat present |
| rx_data | input | DATA_W | Receive byte |
| rx_par | input | 1 | Receive parity lane |
| tx_valid | output | 1 | Transmit beat present |
| tx_data | output | DATA_W | Transmit byte |
| tx_par | output | 1 | Transmit parity lane |
| mem_ready | input | 1 | Local memory can take a request (low = busy) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_rdata | input | DATA_W | Memory read byte, valid in the same cycle as `mem_addr` |

## Verification
The acknowledge beat is due one cycle after the fourth request beat is captured. Read byte k is due k+1 cycles after the acknowledge, and `tx_valid` must be low the cycle after the last byte. A write is stored on the edge that captures its data beat.

The bench drives every beat just after a falling edge. It then counts falling edges from the last beat it drove and samples the transmit lane exactly on the falling edge where each result is due. For ignored requests it watches the transmit lane and both memory strobes for several cycles. It then reads the register bank back through the normal channel to show that nothing changed.

// File: rtl/pkt_mem_responder_pkg.sv
package pkt_mem_responder_pkg;

   typedef enum logic [1:0] {
      OP_MEM_RD = 2'b00,
      OP_MEM_WR = 2'b01,
      OP_REG_RD = 2'b10,
      OP_REG_WR = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } state_e;

   localparam logic [7:0] ACK_POS   = 8'hF0;
   localparam logic [7:0] ACK_NEG   = 8'h0F;
   localparam int unsigned REQ_BEATS = 4;

endpackage

// File: rtl/pktrsp_req_rx.sv
module pktrsp_req_rx
   import pkt_mem_responder_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int ODD_PARITY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par,
   output logic              beat_bad,
   output logic              req_done,
   output op_e               req_op,
   output logic [DATA_W-3:0] req_id,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W:0]   req_len,
   output logic              req_perr
);
   localparam int ID_W  = DATA_W - 2;
   localparam int CNT_W = $clog2(REQ_BEATS);
   localparam int FULL_AW = 2 * DATA_W;

   logic [CNT_W-1:0]   beat_q;
   logic [DATA_W-1:0]  hdr_q;
   logic [DATA_W-1:0]  ahi_q;
   logic [DATA_W-1:0]  alo_q;
   logic               perr_q;
   logic               take;
   logic [FULL_AW-1:0] full_addr;

   generate
      if (ODD_PARITY != 0) begin : g_odd
         assign beat_bad = ~(^{rx_par, rx_data});
      end else begin : g_even
         assign beat_bad = ^{rx_par, rx_data};
      end
   endgenerate

   assign take     = en & rx_valid;
   assign req_done = take && (beat_q == CNT_W'(REQ_BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
         hdr_q  <= '0;
         ahi_q  <= '0;
         alo_q  <= '0;
         perr_q <= 1'b0;
      end else if (take) begin
         case (beat_q)
            CNT_W'(0): begin
               hdr_q  <= rx_data;
               perr_q <= beat_bad;
            end
            CNT_W'(1): begin
               ahi_q  <= rx_data;
               perr_q <= perr_q | beat_bad;
            end
            CNT_W'(2): begin
               alo_q  <= rx_data;
               perr_q <= perr_q | beat_bad;
            end
            default: perr_q <= perr_q;
         endcase
         beat_q <= req_done ? '0 : beat_q + 1'b1;
      end
   end

   assign full_addr = {ahi_q, alo_q};
   assign req_op    = op_e'(hdr_q[DATA_W-1:DATA_W-2]);
   assign req_id    = hdr_q[ID_W-1:0];
   assign req_addr  = full_addr[ADDR_W-1:0];
   assign req_len   = (rx_data == '0) ? {1'b1, {DATA_W{1'b0}}} : {1'b0, rx_data};
   assign req_perr  = perr_q | beat_bad;

   generate
      if (ADDR_W < FULL_AW) begin : g_trim
         logic unused_addr_bits;
         assign unused_addr_bits = ^full_addr[FULL_AW-1:ADDR_W];
      end
   endgenerate

endmodule

// File: rtl/pktrsp_ctl_regs.sv
module pktrsp_ctl_regs #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 4,
   parameter int IDX_W  = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [NREGS*DATA_W-1:0] flat;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
               q <= wr_data;
            end
         end
         assign flat[i*DATA_W +: DATA_W] = q;
      end
   endgenerate

   assign rd_data = flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/pktrsp_tx_lane.sv
module pktrsp_tx_lane #(
   parameter int DATA_W     = 8,
   parameter int ODD_PARITY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] byte_in,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_par
);
   logic par_next;

   generate
      if (ODD_PARITY != 0) begin : g_odd
         assign par_next = ~(^byte_in);
      end else begin : g_even
         assign par_next = ^byte_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
         tx_par   <= 1'b0;
      end else begin
         tx_valid <= load;
         if (load) begin
            tx_data <= byte_in;
            tx_par  <= par_next;
         end
      end
   end

endmodule

// File: rtl/pkt_mem_responder.sv
module pkt_mem_responder
   import pkt_mem_responder_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter int          ADDR_W     = 16,
   parameter int          NREGS      = 4,
   parameter int          ODD_PARITY = 1,
   parameter int unsigned LOCAL_ID   = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_par,
   input  logic              mem_ready,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int ID_W  = DATA_W - 2;
   localparam int LEN_W = DATA_W + 1;
   localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

   initial begin
      if (DATA_W != 8)
         $fatal(1, "DATA_W must be 8 for the four-beat request layout");
      if (ADDR_W < IDX_W || ADDR_W > 2 * DATA_W)
         $fatal(1, "ADDR_W out of range");
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0)
         $fatal(1, "NREGS must be a power of two, at least 2");
      if (LOCAL_ID >= (1 << ID_W))
         $fatal(1, "LOCAL_ID does not fit the device field");
   end

   state_e             state_q;
   logic               reg_sel_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   left_q;

   logic               beat_bad;
   logic               req_done;
   op_e                req_op;
   logic [ID_W-1:0]    req_id;
   logic [ADDR_W-1:0]  req_addr;
   logic [LEN_W-1:0]   req_len;
   logic               req_perr;

   logic               id_hit;
   logic               op_is_reg;
   logic               op_is_wr;
   logic               busy;
   logic               grant;
   logic               respond;
   logic               data_ok;
   logic               last_unit;

   logic               reg_wr;
   logic [DATA_W-1:0]  reg_rdata;
   logic               tx_load;
   logic [DATA_W-1:0]  tx_byte;

   pktrsp_req_rx #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .ODD_PARITY (ODD_PARITY)
   ) req_rx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (state_q == ST_IDLE),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_par   (rx_par),
      .beat_bad (beat_bad),
      .req_done (req_done),
      .req_op   (req_op),
      .req_id   (req_id),
      .req_addr (req_addr),
      .req_len  (req_len),
      .req_perr (req_perr)
   );

   assign id_hit    = (req_id == ID_W'(LOCAL_ID));
   assign op_is_reg = req_op[1];
   assign op_is_wr  = req_op[0];
   assign busy      = !op_is_reg && !mem_ready;
   assign grant     = !req_perr && !busy;
   assign respond   = req_done && id_hit;
   assign data_ok   = rx_valid && !beat_bad;
   assign last_unit = (left_q == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         reg_sel_q <= 1'b0;
         addr_q    <= '0;
         left_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (respond && grant) begin
                  state_q   <= op_is_wr ? ST_WRITE : ST_READ;
                  reg_sel_q <= op_is_reg;
                  addr_q    <= req_addr;
                  left_q    <= req_len;
               end
            end
            ST_READ: begin
               addr_q <= addr_q + ADDR_W'(1);
               left_q <= left_q - LEN_W'(1);
               if (last_unit) state_q <= ST_IDLE;
            end
            ST_WRITE: begin
               if (rx_valid) begin
                  addr_q <= addr_q + ADDR_W'(1);
                  left_q <= left_q - LEN_W'(1);
                  if (last_unit) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd    = (state_q == ST_READ) && !reg_sel_q;
   assign mem_wr    = (state_q == ST_WRITE) && !reg_sel_q && data_ok;
   assign mem_addr  = addr_q;
   assign mem_wdata = rx_data;
   assign reg_wr    = (state_q == ST_WRITE) && reg_sel_q && data_ok;

   pktrsp_ctl_regs #(
      .DATA_W (DATA_W),
      .NREGS  (NREGS),
      .IDX_W  (IDX_W)
   ) ctl_regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_idx  (addr_q[IDX_W-1:0]),
      .wr_data (rx_data),
      .rd_idx  (addr_q[IDX_W-1:0]),
      .rd_data (reg_rdata)
   );

   always_comb begin
      tx_load = 1'b0;
      tx_byte = '0;
      if (state_q == ST_IDLE) begin
         tx_load = respond;
         tx_byte = grant ? ACK_POS : ACK_NEG;
      end else if (state_q == ST_READ) begin
         tx_load = 1'b1;
         tx_byte = reg_sel_q ? reg_rdata : mem_rdata;
      end
   end

   pktrsp_tx_lane #(
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY)
   ) tx_lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .byte_in  (tx_byte),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_par   (tx_par)
   );

endmodule

// File: rtl/pkt_mem_responder_chk.sv
module pkt_mem_responder_chk
   import pkt_mem_responder_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int ODD_PARITY = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_par,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam logic PAR_SUM = (ODD_PARITY != 0) ? 1'b1 : 1'b0;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!tx_valid && !mem_rd && !mem_wr));

   // R7
   tx_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ((^{tx_par, tx_data}) == PAR_SUM));

   // R4
   ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> (tx_data == ACK_POS || tx_data == ACK_NEG));

   // R5
   nak_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_valid) && tx_data == ACK_NEG) |=> !tx_valid);

   // R8
   read_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> tx_valid);

   // R8
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R9
   write_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (rx_valid && !mem_rd));

endmodule

bind pkt_mem_responder pkt_mem_responder_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .ODD_PARITY (ODD_PARITY)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .tx_valid (tx_valid),
   .tx_data  (tx_data),
   .tx_par   (tx_par),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr)
);

// File: tb/pkt_mem_responder_tb.sv
module pkt_mem_responder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW     = 10;
   localparam int NR     = 4;
   localparam int MY_ID  = 21;
   localparam int MEM_SZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = 8'h00;
   logic          rx_par = 1'b0;
   logic          tx_valid;
   logic [7:0]    tx_data;
   logic          tx_par;
   logic          mem_ready = 1'b1;
   logic          mem_rd;
   logic          mem_wr;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata;

   logic [7:0] model   [MEM_SZ];
   logic [7:0] exp_mem [MEM_SZ];
   logic [7:0] exp_reg [NR];

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pkt_mem_responder #(
      .DATA_W     (8),
      .ADDR_W     (AW),
      .NREGS      (NR),
      .ODD_PARITY (1),
      .LOCAL_ID   (MY_ID)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_par    (rx_par),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_par    (tx_par),
      .mem_ready (mem_ready),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   assign mem_rdata = model[mem_addr];
   always @(posedge clk) if (mem_wr) model[mem_addr] <= mem_wdata;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic drive_beat(input logic [7:0] d, input bit bad);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = d;
      rx_par   = (~(^d)) ^ bad;
   endtask

   // kind: 0 = no answer, 1 = positive, 2 = negative
   task automatic xact(input int op, input int id, input int addr, input int cnt,
                       input int bad_beat, input bit rdy, input int bad_data,
                       input int seed, input string tag);
      logic [7:0] b [4];
      int len;
      int kind;
      string atag;
      b[0] = {2'(op), 6'(id)};
      b[1] = 8'(addr >> 8);
      b[2] = 8'(addr);
      b[3] = 8'(cnt);
      len  = ((cnt % 256) == 0) ? 256 : (cnt % 256);
      if (id != MY_ID) begin
         kind = 0; atag = "R3";
      end else if (bad_beat >= 0) begin
         kind = 2; atag = "R6";
      end else if (op < 2 && !rdy) begin
         kind = 2; atag = "R5";
      end else begin
         kind = 1; atag = (op >= 2 && !rdy) ? "R5" : "R4";
      end
      mem_ready = rdy;
      for (int i = 0; i < 4; i++) drive_beat(b[i], i == bad_beat);
      @(negedge clk);
      mem_ready = 1'b1;
      if (kind == 0) begin
         rx_valid = 1'b0;
         check(!tx_valid && !mem_wr && !mem_rd, "R3", int'(tx_valid), 0);
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!tx_valid && !mem_wr && !mem_rd, "R3", int'({tx_valid, mem_wr, mem_rd}), 0);
         end
         return;
      end
      check(tx_valid && tx_data == ((kind == 1) ? 8'hF0 : 8'h0F), atag,
            int'({tx_valid, tx_data}), int'({1'b1, (kind == 1) ? 8'hF0 : 8'h0F}));
      check((^{tx_par, tx_data}) == 1'b1, "R7", int'(tx_par), int'(~(^tx_data)));
      if (kind == 2) begin
         rx_valid = 1'b0;
         @(negedge clk);
         check(!tx_valid, atag, int'(tx_valid), 0);
         return;
      end
      if (op == 0 || op == 2) begin
         rx_valid = 1'b0;
         for (int k = 0; k < len; k++) begin
            logic [7:0] e;
            @(negedge clk);
            e = (op == 0) ? exp_mem[(addr + k) % MEM_SZ] : exp_reg[(addr + k) % NR];
            check(tx_valid && tx_data == e, tag, int'({tx_valid, tx_data}), int'({1'b1, e}));
            check((^{tx_par, tx_data}) == 1'b1, "R7", int'(tx_par), int'(~(^tx_data)));
         end
         @(negedge clk);
         check(!tx_valid, tag, int'(tx_valid), 0);
      end else begin
         for (int k = 0; k < len; k++) begin
            logic [7:0] d;
            if (k != 0) @(negedge clk);
            d = 8'((seed * 31 + k * 7 + 5) & 255);
            rx_valid = 1'b1;
            rx_data  = d;
            rx_par   = (~(^d)) ^ (k == bad_data);
            if (k != bad_data) begin
               if (op == 1) exp_mem[(addr + k) % MEM_SZ] = d;
               else         exp_reg[(addr + k) % NR] = d;
            end
         end
         @(negedge clk);
         rx_valid = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1-R12 overall: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < MEM_SZ; a++) begin
         model[a]   = 8'((a * 7 + 3) & 255);
         exp_mem[a] = 8'((a * 7 + 3) & 255);
      end
      for (int r = 0; r < NR; r++) exp_reg[r] = 8'h00;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!tx_valid && !mem_rd && !mem_wr, "R1", int'({tx_valid, mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_valid, "R1", int'(tx_valid), 0);
      xact(2, MY_ID, 0, 4, -1, 1, -1, 0, "R1");

      // R4 R5 R6 R8 R9 R11: sweep opcode x ready x faulty request beat
      for (int op = 0; op < 4; op++)
         for (int rdy = 0; rdy < 2; rdy++)
            for (int bb = -1; bb < 4; bb++)
               xact(op, MY_ID, (op * 97 + (bb + 1) * 13 + rdy * 5 + 200) % MEM_SZ, 3,
                    bb, rdy[0], -1, op * 10 + bb + rdy, (op >= 2) ? "R11" : "R8");

      // R3: foreign device numbers, clean and with parity faults
      for (int i = 0; i < 6; i++) begin
         int fid;
         fid = (i == 0) ? 0 : (i == 1) ? 20 : (i == 2) ? 22 : (i == 3) ? 63 : (i == 4) ? 53 : 5;
         xact(3, fid, i, 2, (i == 5) ? 1 : -1, 1, -1, 99, "R3");
         xact(1, fid, 40 + i, 2, -1, 1, -1, 98, "R3");
      end
      xact(2, MY_ID, 0, 4, -1, 1, -1, 0, "R3");
      xact(0, MY_ID, 40, 8, -1, 1, -1, 0, "R3");

      // R2 R8 R9: address wrap at the top of memory, high address byte used
      xact(1, MY_ID, MEM_SZ - 2, 4, -1, 1, -1, 7, "R9");
      xact(0, MY_ID, MEM_SZ - 2, 4, -1, 1, -1, 0, "R2/R8");
      xact(0, MY_ID, 770, 5, -1, 1, -1, 0, "R2");

      // R12: count zero means 256
      xact(0, MY_ID, 100, 0, -1, 1, -1, 0, "R12");
      xact(1, MY_ID, 512, 0, -1, 1, -1, 11, "R12");
      xact(0, MY_ID, 512, 0, -1, 1, -1, 0, "R12");

      // R10: faulty data beats are skipped but consume their slot
      xact(1, MY_ID, 300, 4, -1, 1, 1, 21, "R10");
      xact(0, MY_ID, 300, 4, -1, 1, -1, 0, "R10");
      xact(3, MY_ID, 1, 3, -1, 1, 0, 33, "R10");
      xact(2, MY_ID, 0, 4, -1, 1, -1, 0, "R10");

      // R11: register index wraps
      xact(3, MY_ID, 6, 3, -1, 0, -1, 44, "R11");
      xact(2, MY_ID, 0, 4, -1, 0, -1, 0, "R11");
      xact(2, MY_ID, 3, 6, -1, 1, -1, 0, "R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule